// File: doc/BRIEF.md
# Banked Indirect Byte-RAM Window

This block gives a host that can only reach a small space of byte registers a way into a much larger internal byte RAM (4096 entries by default). A pointer is loaded through two registers: one for the low eight bits and one for the remaining upper bits. The stored byte at that pointer is then read or written through a single data register. A control register holds an auto-step flag. When the flag is set, every data-register access moves the pointer on by one, so a whole buffer can be streamed with repeated accesses to one register.

The window is decoded only while the external bank-select input is high. With bank select low, the registers are invisible. The block also keeps an 8-bit tally of every register write the host makes while the block is selected. Host accesses use one clock with a select, a write strobe, a read strobe, an 8-bit register address and a write byte. Read data comes back registered, one clock after the read strobe.

Top module: `xram_window`

## Requirements
- R1: After reset the pointer is 000h, the auto-step flag is 0, the write tally is 0 and `rdData` is 00h.
- R2: While `bankSel` is 0, an accepted write changes no window state (pointer, flag, RAM), and an accepted read returns 00h. The write tally still counts that write.
- R3: A write to 50h loads pointer bits 7:0. A write to 51h loads pointer bits 11:8 from data bits 3:0. Reading 51h returns the upper pointer bits in bits 3:0 with bits 7:4 as 0.
- R4: A write to 53h stores the byte at the current pointer. A read of 53h returns the byte at the current pointer. All read data appears on `rdData` one clock after the read strobe.
- R5: With the auto-step flag at 0, repeated accesses to 53h all use the same pointer value.
- R6: The auto-step flag is bit 5 of register 4Ah. Reading 4Ah returns the flag in bit 5 and 0 in every other bit.
- R7: With the auto-step flag at 1, the pointer increases by one after each read or write of 53h. The access itself uses the pointer value from before the step.
- R8: Stepping the pointer from FFFh gives 000h.
- R9: Register 5Eh reads the write tally. The tally rises by one, modulo 256, on every write accepted while `sel` is 1, in either bank and to any address. A write to 5Eh itself only counts and does not load the tally.
- R10: While `sel` is 0, no strobe has any effect, and `rdData` keeps its value whenever no read is accepted.
- R11: Any other address in the bank reads as 00h and ignores writes.
- R12: If `wrEn` and `rdEn` are both high, the access is a write only and `rdData` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Block select, active high |
| bankSel | input | 1 | High when the extended bank is selected |
| wrEn | input | 1 | Write strobe for this cycle |
| rdEn | input | 1 | Read strobe for this cycle |
| regAddr | input | 8 | Register address |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Registered read byte |

## Verification
The data port is driven with streaming runs that have auto-step on and with repeated single-address runs that have it off. Reading back then shows whether the pointer steps on reads, on writes, on both or on neither. A whole-RAM burst fill followed by spot reads separates a correct store from an off-by-one pointer step. Loading the pointer to FFFh and stepping it tells a wrap to 000h apart from a carry leaking into wider state. Random traffic mixes bank-select low, select low, both strobes at once, and reserved addresses among real accesses. Each of these must leave the window state and the tally exactly as the bench model predicts.

// File: rtl/xram_pkg.sv
package xram_pkg;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_LO,
    SRC_HI,
    SRC_CTRL,
    SRC_RAM,
    SRC_CNT
  } rdSrc_t;

  typedef struct packed {
    logic   ldLo;
    logic   ldHi;
    logic   ldCtrl;
    logic   ramWr;
    logic   bump;
    logic   tally;
    logic   rdLoad;
    rdSrc_t src;
  } strobes_t;

endpackage

// File: rtl/xram_ctrl.sv
module xram_ctrl
  import xram_pkg::*;
#(
  parameter int         REG_W    = 8,
  parameter logic [7:0] OFF_CTRL = 8'h4A,
  parameter logic [7:0] OFF_LO   = 8'h50,
  parameter logic [7:0] OFF_HI   = 8'h51,
  parameter logic [7:0] OFF_DATA = 8'h53,
  parameter logic [7:0] OFF_CNT  = 8'h5E
) (
  input  logic             sel,
  input  logic             bankSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [REG_W-1:0] regAddr,
  input  logic             burstEn,
  output strobes_t         st
);

  logic wrAcc;
  logic rdAcc;

  assign wrAcc = sel && wrEn;
  assign rdAcc = sel && rdEn && !wrEn;

  always_comb begin
    st        = '0;
    st.src    = SRC_ZERO;
    st.tally  = wrAcc;
    st.rdLoad = rdAcc;
    if (wrAcc && bankSel) begin
      case (regAddr)
        OFF_LO:   st.ldLo   = 1'b1;
        OFF_HI:   st.ldHi   = 1'b1;
        OFF_CTRL: st.ldCtrl = 1'b1;
        OFF_DATA: begin
          st.ramWr = 1'b1;
          st.bump  = burstEn;
        end
        default: ;
      endcase
    end
    if (rdAcc && bankSel) begin
      case (regAddr)
        OFF_LO:   st.src = SRC_LO;
        OFF_HI:   st.src = SRC_HI;
        OFF_CTRL: st.src = SRC_CTRL;
        OFF_CNT:  st.src = SRC_CNT;
        OFF_DATA: begin
          st.src  = SRC_RAM;
          st.bump = burstEn;
        end
        default:  st.src = SRC_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/xram_datapath.sv
module xram_datapath
  import xram_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 12,
  parameter int BURST_BIT = 5,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] xAddr,
  output logic              burstEn,
  output logic [CNT_W-1:0]  wrCount
);

  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ramQ;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (st.ramWr) mem[xAddr] <= wrData;
  end

  assign ramQ = mem[xAddr];

  always_comb begin
    rdNext = '0;
    case (st.src)
      SRC_LO:   rdNext = xAddr[DATA_W-1:0];
      SRC_HI:   rdNext = {{(DATA_W-HI_W){1'b0}}, xAddr[ADDR_W-1:DATA_W]};
      SRC_CTRL: rdNext[BURST_BIT] = burstEn;
      SRC_RAM:  rdNext = ramQ;
      SRC_CNT:  rdNext = DATA_W'(wrCount);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xAddr   <= '0;
      burstEn <= 1'b0;
      wrCount <= '0;
      rdData  <= '0;
    end else begin
      if (st.ldLo)   xAddr[DATA_W-1:0]      <= wrData;
      if (st.ldHi)   xAddr[ADDR_W-1:DATA_W] <= wrData[HI_W-1:0];
      if (st.bump)   xAddr                  <= xAddr + 1'b1;
      if (st.ldCtrl) burstEn                <= wrData[BURST_BIT];
      if (st.tally)  wrCount                <= wrCount + 1'b1;
      if (st.rdLoad) rdData                 <= rdNext;
    end
  end

endmodule

// File: rtl/xram_window.sv
module xram_window
  import xram_pkg::*;
#(
  parameter int         DATA_W    = 8,
  parameter int         ADDR_W    = 12,
  parameter int         BURST_BIT = 5,
  parameter int         CNT_W     = 8,
  parameter logic [7:0] OFF_CTRL  = 8'h4A,
  parameter logic [7:0] OFF_LO    = 8'h50,
  parameter logic [7:0] OFF_HI    = 8'h51,
  parameter logic [7:0] OFF_DATA  = 8'h53,
  parameter logic [7:0] OFF_CNT   = 8'h5E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              bankSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  strobes_t          st;
  logic [ADDR_W-1:0] xAddr;
  logic              burstEn;
  logic [CNT_W-1:0]  wrCount;

  xram_ctrl #(
    .REG_W(8), .OFF_CTRL(OFF_CTRL), .OFF_LO(OFF_LO), .OFF_HI(OFF_HI),
    .OFF_DATA(OFF_DATA), .OFF_CNT(OFF_CNT)
  ) u_ctrl (
    .sel(sel), .bankSel(bankSel), .wrEn(wrEn), .rdEn(rdEn),
    .regAddr(regAddr), .burstEn(burstEn), .st(st)
  );

  xram_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BURST_BIT(BURST_BIT), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData), .rdData(rdData),
    .xAddr(xAddr), .burstEn(burstEn), .wrCount(wrCount)
  );

endmodule

// File: rtl/xram_window_chk.sv
module xram_window_chk #(
  parameter int         DATA_W   = 8,
  parameter int         ADDR_W   = 12,
  parameter int         CNT_W    = 8,
  parameter logic [7:0] OFF_DATA = 8'h53
) (
  input logic              clk,
  input logic              rstN,
  input logic              sel,
  input logic              bankSel,
  input logic              wrEn,
  input logic              rdEn,
  input logic [7:0]        regAddr,
  input logic [DATA_W-1:0] rdData,
  input logic [ADDR_W-1:0] xAddr,
  input logic              burstEn,
  input logic [CNT_W-1:0]  wrCount
);

  logic dataAcc;
  logic rdAcc;
  assign dataAcc = sel && bankSel && (regAddr == OFF_DATA) && (wrEn || rdEn);
  assign rdAcc   = sel && rdEn && !wrEn;

  // R9
  tally_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sel && wrEn) |=> wrCount == CNT_W'($past(wrCount) + 1'b1));

  // R10
  tally_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sel && wrEn) |=> $stable(wrCount));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdAcc |=> $stable(rdData));

  // R2
  bank0_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && !bankSel) |=> rdData == '0);

  // R2
  bank0_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bankSel |=> $stable(xAddr));

  // R7
  step_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && burstEn) |=> xAddr == ADDR_W'($past(xAddr) + 1'b1));

  // R5
  fixed_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && !burstEn) |=> $stable(xAddr));

  // R11
  reserved_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && bankSel && regAddr == 8'h52) |=> rdData == '0);

endmodule

bind xram_window xram_window_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFF_DATA(OFF_DATA)
) u_chk (
  .clk(clk), .rstN(rstN), .sel(sel), .bankSel(bankSel), .wrEn(wrEn),
  .rdEn(rdEn), .regAddr(regAddr), .rdData(rdData), .xAddr(xAddr),
  .burstEn(burstEn), .wrCount(wrCount)
);

// File: tb/tb_xram_window.sv
module tb_xram_window;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sel = 1'b0, bankSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] regAddr = '0, wrData = '0;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]  mMem [4096];
  logic [11:0] mAddr = '0;
  logic        mBurst = 1'b0;
  logic [7:0]  mCnt = '0;
  logic [7:0]  mRd = '0;

  always #2 clk = ~clk;

  xram_window dut (
    .clk(clk), .rstN(rstN), .sel(sel), .bankSel(bankSel), .wrEn(wrEn),
    .rdEn(rdEn), .regAddr(regAddr), .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic string tagFor(input bit s, input bit b, input bit w,
                                   input bit r, input logic [7:0] a);
    if (!s) return "R10";
    if (w && r) return "R12";
    if (!b) return "R2";
    case (a)
      8'h50, 8'h51: return "R3";
      8'h4A: return "R6";
      8'h53: return mBurst ? "R7" : "R5";
      8'h5E: return "R9";
      default: return "R11";
    endcase
  endfunction

  // one host cycle, model update, then compare rdData after the edge
  task automatic access(input bit s, input bit b, input bit w, input bit r,
                        input logic [7:0] a, input logic [7:0] d, input string tag);
    bit wrAcc, rdAcc;
    string t;
    t = (tag == "") ? tagFor(s, b, w, r, a) : tag;
    sel = s; bankSel = b; wrEn = w; rdEn = r; regAddr = a; wrData = d;
    wrAcc = s && w;
    rdAcc = s && r && !w;
    if (wrAcc) mCnt = mCnt + 8'd1;
    if (wrAcc && b) begin
      case (a)
        8'h50: mAddr[7:0] = d;
        8'h51: mAddr[11:8] = d[3:0];
        8'h4A: mBurst = d[5];
        8'h53: begin mMem[mAddr] = d; if (mBurst) mAddr = mAddr + 12'd1; end
        default: ;
      endcase
    end
    if (rdAcc) begin
      if (!b) mRd = 8'h00;
      else case (a)
        8'h50: mRd = mAddr[7:0];
        8'h51: mRd = {4'h0, mAddr[11:8]};
        8'h4A: mRd = {2'b00, mBurst, 5'b0};
        8'h53: begin mRd = mMem[mAddr]; if (mBurst) mAddr = mAddr + 12'd1; end
        8'h5E: mRd = mCnt;
        default: mRd = 8'h00;
      endcase
    end
    @(negedge clk);
    sel = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    check(t, rdData, mRd);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    access(1'b1, 1'b1, 1'b1, 1'b0, a, d, tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    access(1'b1, 1'b1, 1'b0, 1'b1, a, 8'h00, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] pick [8];
    pick = '{8'h50, 8'h51, 8'h4A, 8'h53, 8'h53, 8'h53, 8'h5E, 8'h00};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1", rdData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset values visible through the window
    rd(8'h50, "R1"); rd(8'h51, "R1"); rd(8'h4A, "R1"); rd(8'h5E, "R1");

    // R6 only bit 5 kept; R7 burst fill of whole RAM
    wr(8'h4A, 8'hFF, "R6");
    rd(8'h4A, "R6");
    wr(8'h50, 8'h00, "R3"); wr(8'h51, 8'h00, "R3");
    for (int i = 0; i < 4096; i++) wr(8'h53, 8'((i * 7) + 3), "R7");
    rd(8'h50, "R8"); rd(8'h51, "R8");
    // R4 spot reads with auto-step
    wr(8'h51, 8'hA7, "R3"); rd(8'h51, "R3");
    wr(8'h50, 8'h3C, "R3");
    rd(8'h53, "R4"); rd(8'h53, "R7"); rd(8'h50, "R7");

    // R8 wrap from FFFh
    wr(8'h50, 8'hFF, "R3"); wr(8'h51, 8'h0F, "R3");
    rd(8'h53, "R8"); rd(8'h50, "R8"); rd(8'h51, "R8");

    // R5 fixed pointer
    wr(8'h4A, 8'h00, "R6");
    wr(8'h53, 8'h5A, "R5"); wr(8'h53, 8'hC3, "R5");
    rd(8'h53, "R5"); rd(8'h53, "R5"); rd(8'h50, "R5");

    // R2 bank 0 hidden, R10 select low, R11 reserved, R12 both strobes
    access(1'b1, 1'b0, 1'b1, 1'b0, 8'h50, 8'h99, "R2");
    access(1'b1, 1'b0, 1'b0, 1'b1, 8'h50, 8'h00, "R2");
    rd(8'h50, "R2");
    access(1'b0, 1'b1, 1'b1, 1'b0, 8'h50, 8'h77, "R10");
    rd(8'h50, "R10");
    wr(8'h52, 8'hEE, "R11"); rd(8'h52, "R11");
    access(1'b1, 1'b1, 1'b1, 1'b1, 8'h50, 8'h12, "R12");
    rd(8'h50, "R12");

    // R9 tally wrap and ignored writes to the tally register
    for (int i = 0; i < 300; i++) access(1'b1, i[0], 1'b1, 1'b0, 8'h5E, 8'h77, "R9");
    rd(8'h5E, "R9");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      bit s, b, w, r;
      logic [7:0] a;
      s = ($urandom % 8) != 0;
      b = ($urandom % 6) != 0;
      w = $urandom % 2;
      r = ($urandom % 16 == 0) ? 1'b1 : !w;
      a = pick[$urandom % 8];
      if (a == 8'h00) a = 8'($urandom);
      access(s, b, w, r, a, 8'($urandom), "");
    end
    rd(8'h5E, "R9"); rd(8'h50, "R3"); rd(8'h51, "R3");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule